// File: doc/BRIEF.md
# Two-Byte DAC Code Loader with Output Forcing

This block assembles a 12-bit converter code from an 8-bit parallel bus. A processor writes the code as two bytes, each routed by its own active-low select (one for the upper byte, one for the lower byte), and each access is qualified by an active-low write strobe. The bytes land in a holding register. A separate active-low load input decides whether the same access also moves the assembled code into the converter register that drives the output. An access with neither byte selected but load asserted copies the holding register across, so several converters can be updated together.

A mode pin and a control pin share two jobs. While the mode pin is high, the control pin picks how the 12 bits are spread over the two bytes (left- or right-justified), and that choice is latched. While the mode pin is low, the output is forced to all zeros or all ones, and the converter register keeps its contents for when the pin returns high. The bus is a plain strobed register port, not a stream: there is no valid/ready pair and no back-pressure, and every completed write is accepted.

All inputs are synchronous to `clk`. A write takes effect on the clock cycle in which the strobe is first seen high again after being low. The selects, load level and bus data are sampled in that cycle.

Top module: `byte_dac_loader`

## Requirements
- R1: While `wr_n` stays high, neither the holding register nor the converter register changes, whatever `sel_hi_n`, `sel_lo_n`, `load_n` and `bus_data` do.
- R2: A write is applied on the rising edge of `clk` that ends the first cycle in which `wr_n` is high after being low. It uses the data, selects and load level present in that cycle, so `dac_code` changes one clock edge after `wr_n` is released and not while `wr_n` is held low.
- R3: A write with `sel_hi_n`=1, `sel_lo_n`=0 and `load_n`=1 updates only the lower-byte field of the holding register and leaves `dac_code` unchanged.
- R4: A write with `sel_hi_n`=0, `sel_lo_n`=1 and `load_n`=1 updates only the upper-byte field of the holding register and leaves `dac_code` unchanged.
- R5: A single-byte write with `load_n`=0 also loads the converter register with the merged code: the new byte combined with the stored field of the other byte.
- R6: A write with both selects high copies the holding register into the converter register when `load_n`=0, and changes nothing when `load_n`=1.
- R7: A write with both selects low loads both fields from the same bus value under the current packing (left: {d[7:0], d[7:4]}; right: {d[3:0], d[7:0]}). With `load_n`=0 the result also reaches the converter register.
- R8: With `fmt_ovr`=1, `mode_ctl`=0 selects left packing (upper byte = code[11:4], lower byte bits 7..4 = code[3:0], lower byte bits 3..0 ignored). `mode_ctl`=1 selects right packing (upper byte bits 3..0 = code[11:8], upper byte bits 7..4 ignored, lower byte = code[7:0]). The packing is latched while `fmt_ovr`=1 and held while `fmt_ovr`=0.
- R9: With `fmt_ovr`=0, `dac_code` is 12'h000 when `mode_ctl`=0 and 12'hFFF when `mode_ctl`=1. The converter register is preserved and can still be written, and it reappears on `dac_code` once `fmt_ovr` returns high.
- R10: Reset (`rst_n` low) clears both the holding register and the converter register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe; the access is applied on its release |
| sel_hi_n | input | 1 | Active-low select for the upper byte |
| sel_lo_n | input | 1 | Active-low select for the lower byte |
| load_n | input | 1 | Active-low request to also update the converter register |
| bus_data | input | BUS_W (8) | Byte data bus |
| fmt_ovr | input | 1 | High: packing select mode; low: output forcing mode |
| mode_ctl | input | 1 | Packing choice or forced value, depending on `fmt_ovr` |
| dac_code | output | CODE_W (12) | Code presented to the converter |

## Verification
The bench builds the block with its default widths, a 12-bit code over an 8-bit bus. This leaves a 4-bit partial field that sits at opposite ends of the code in the two packings. With these values, every ignored nibble, every partial-field merge and the shared-value load with both selects low produce distinct, hand-computable codes. Holding-register contents are made visible at the output through load-only copy writes. The strobe-release timing is probed by changing bus data while the strobe is still low.

// File: rtl/dacl_pkg.sv
package dacl_pkg;
  typedef enum logic {
    PACK_LEFT  = 1'b0,
    PACK_RIGHT = 1'b1
  } pack_e;
endpackage

// File: rtl/dacl_strobe_detect.sv
module dacl_strobe_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  output logic strobe
);
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end

  // release of the strobe: low last cycle, high now
  assign strobe = wr_n & ~wr_q;

  // R2: one applied access per release
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/dacl_format_ctl.sv
module dacl_format_ctl
  import dacl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fmt_ovr,
  input  logic  mode_ctl,
  output pack_e pack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pack <= PACK_LEFT;
    else if (fmt_ovr) pack <= mode_ctl ? PACK_RIGHT : PACK_LEFT;
  end

  // R8: packing choice is held while forcing is active
  a_r8_pack_held: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_ovr |=> $stable(pack));
endmodule

// File: rtl/dacl_input_reg.sv
module dacl_input_reg
  import dacl_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              sel_hi_n,
  input  logic              sel_lo_n,
  input  pack_e             pack,
  input  logic [BUS_W-1:0]  bus_data,
  output logic [CODE_W-1:0] in_code,
  output logic [CODE_W-1:0] in_next
);
  localparam int NIB_W = CODE_W - BUS_W;

  logic [CODE_W-1:0] hi_mask, lo_mask, hi_val, lo_val;

  always_comb begin
    if (pack == PACK_LEFT) begin
      hi_mask = {{BUS_W{1'b1}}, {NIB_W{1'b0}}};
      hi_val  = {bus_data, {NIB_W{1'b0}}};
      lo_val  = {{BUS_W{1'b0}}, bus_data[BUS_W-1 -: NIB_W]};
    end else begin
      hi_mask = {{NIB_W{1'b1}}, {BUS_W{1'b0}}};
      hi_val  = {bus_data[NIB_W-1:0], {BUS_W{1'b0}}};
      lo_val  = {{NIB_W{1'b0}}, bus_data};
    end
    lo_mask = ~hi_mask;
  end

  always_comb begin
    in_next = in_code;
    if (!sel_hi_n) in_next = (in_next & ~hi_mask) | hi_val;
    if (!sel_lo_n) in_next = (in_next & ~lo_mask) | lo_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      in_code <= '0;
    else if (strobe) in_code <= in_next;
  end

  // R1: no change without an applied write
  a_r1_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(in_code));
  // R6: a write with no byte selected leaves the holding register alone
  a_r6_input_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && sel_hi_n && sel_lo_n) |=> $stable(in_code));
endmodule

// File: rtl/dacl_dac_reg.sv
module dacl_dac_reg #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              sel_hi_n,
  input  logic              sel_lo_n,
  input  logic              load_n,
  input  logic [CODE_W-1:0] in_code,
  input  logic [CODE_W-1:0] in_next,
  output logic [CODE_W-1:0] dac_reg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dac_reg <= '0;
    else if (strobe && !load_n) dac_reg <= in_next;
  end

  // R1: converter register holds without an applied write
  a_r1_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(dac_reg));
  // R3: byte writes without load do not touch the converter register
  a_r3_no_load_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && load_n) |=> $stable(dac_reg));
  // R6: load-only access copies the holding register
  a_r6_copy_input: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && sel_hi_n && sel_lo_n && !load_n) |=> (dac_reg == $past(in_code)));
endmodule

// File: rtl/byte_dac_loader.sv
module byte_dac_loader
  import dacl_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              sel_hi_n,
  input  logic              sel_lo_n,
  input  logic              load_n,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              fmt_ovr,
  input  logic              mode_ctl,
  output logic [CODE_W-1:0] dac_code
);
  logic              strobe;
  pack_e             pack;
  logic [CODE_W-1:0] in_code, in_next, dac_reg;

  dacl_strobe_detect u_strobe (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .strobe(strobe)
  );

  dacl_format_ctl u_fmt (
    .clk(clk), .rst_n(rst_n), .fmt_ovr(fmt_ovr), .mode_ctl(mode_ctl), .pack(pack)
  );

  dacl_input_reg #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_in (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sel_hi_n(sel_hi_n),
    .sel_lo_n(sel_lo_n), .pack(pack), .bus_data(bus_data),
    .in_code(in_code), .in_next(in_next)
  );

  dacl_dac_reg #(.CODE_W(CODE_W)) u_dac (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sel_hi_n(sel_hi_n),
    .sel_lo_n(sel_lo_n), .load_n(load_n), .in_code(in_code),
    .in_next(in_next), .dac_reg(dac_reg)
  );

  // forcing mux: register contents are only bypassed, never altered
  always_comb begin
    if (fmt_ovr) dac_code = dac_reg;
    else         dac_code = {CODE_W{mode_ctl}};
  end

  // R9: forced low value
  a_r9_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_ovr && !mode_ctl) |-> (dac_code == '0));
  // R9: forced high value
  a_r9_force_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_ovr && mode_ctl) |-> (dac_code == '1));
  // R9: register shows through when not forcing
  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_ovr |-> (dac_code == dac_reg));
endmodule

// File: tb/tb_byte_dac_loader.sv
module tb_byte_dac_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic        sel_hi_n = 1'b1;
  logic        sel_lo_n = 1'b1;
  logic        load_n = 1'b1;
  logic [7:0]  bus_data = 8'h00;
  logic        fmt_ovr = 1'b1;
  logic        mode_ctl = 1'b0;
  logic [11:0] dac_code;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byte_dac_loader dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_hi_n(sel_hi_n),
    .sel_lo_n(sel_lo_n), .load_n(load_n), .bus_data(bus_data),
    .fmt_ovr(fmt_ovr), .mode_ctl(mode_ctl), .dac_code(dac_code)
  );

  task automatic check(input string req, input logic [11:0] exp);
    tests++;
    if (dac_code !== exp) begin
      fails++;
      $display("FAIL %s: dac_code=%h expected %h", req, dac_code, exp);
    end
  endtask

  task automatic set_mode(input logic f, input logic c);
    @(negedge clk); fmt_ovr = f; mode_ctl = c;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic hi_n, input logic lo_n,
                           input logic ld_n, input logic [7:0] d);
    @(negedge clk);
    bus_data = d; sel_hi_n = hi_n; sel_lo_n = lo_n; load_n = ld_n; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); sel_hi_n = 1'b1; sel_lo_n = 1'b1; load_n = 1'b1;
  endtask

  task automatic t_reset_state;
    @(negedge clk); check("R10 reset", 12'h000);
  endtask

  task automatic t_right_bytes;
    set_mode(1'b1, 1'b1);
    bus_write(1'b0, 1'b1, 1'b1, 8'hA5);
    check("R4 upper byte no load", 12'h000);
    bus_write(1'b1, 1'b0, 1'b0, 8'h3C);
    check("R5 R8 right merge", 12'h53C);
  endtask

  task automatic t_left_bytes;
    set_mode(1'b1, 1'b0);
    bus_write(1'b0, 1'b1, 1'b0, 8'h12);
    check("R5 R8 left upper merge", 12'h12C);
    bus_write(1'b1, 1'b0, 1'b1, 8'hF7);
    check("R3 lower byte no load", 12'h12C);
    bus_write(1'b1, 1'b1, 1'b1, 8'h00);
    check("R6 no select no load", 12'h12C);
    bus_write(1'b1, 1'b1, 1'b0, 8'h00);
    check("R6 copy, R8 low nibble ignored", 12'h12F);
  endtask

  task automatic t_idle_strobe;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sel_hi_n = i[0]; sel_lo_n = i[1]; load_n = i[2]; bus_data = 8'h5A + 8'(i);
    end
    @(negedge clk); sel_hi_n = 1'b1; sel_lo_n = 1'b1; load_n = 1'b1;
    check("R1 idle output", 12'h12F);
    bus_write(1'b1, 1'b1, 1'b0, 8'h00);
    check("R1 idle holding register", 12'h12F);
  endtask

  task automatic t_both_selects;
    bus_write(1'b0, 1'b0, 1'b0, 8'hB7);
    check("R7 both left", 12'hB7B);
    set_mode(1'b1, 1'b1);
    bus_write(1'b0, 1'b0, 1'b0, 8'h6E);
    check("R7 both right", 12'hE6E);
  endtask

  task automatic t_override;
    set_mode(1'b0, 1'b0);
    check("R9 force zero", 12'h000);
    set_mode(1'b0, 1'b1);
    check("R9 force ones", 12'hFFF);
    set_mode(1'b0, 1'b0);
    bus_write(1'b1, 1'b0, 1'b0, 8'h11);
    check("R9 forced during write", 12'h000);
    set_mode(1'b1, 1'b0);
    check("R9 R8 register back, right packing held", 12'hE11);
    set_mode(1'b1, 1'b1);
  endtask

  task automatic t_release_timing;
    @(negedge clk);
    bus_data = 8'h00; sel_hi_n = 1'b1; sel_lo_n = 1'b0; load_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    check("R2 no change while low", 12'hE11);
    bus_data = 8'h44;
    @(negedge clk);
    wr_n = 1'b1;
    #2 check("R2 not before edge", 12'hE11);
    @(negedge clk);
    check("R2 release-cycle data", 12'hE44);
    sel_lo_n = 1'b1; load_n = 1'b1;
  endtask

  task automatic t_mid_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check("R10 reset clears output", 12'h000);
    rst_n = 1'b1;
    bus_write(1'b1, 1'b1, 1'b0, 8'h00);
    check("R10 holding register cleared", 12'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_right_bytes();
    t_left_bytes();
    t_idle_strobe();
    t_both_selects();
    t_override();
    t_release_timing();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule